// File: doc/BRIEF.md
# Prioritized Fixed-Vector Interrupt Controller

This block decides which interrupt a small 8-bit processor core services next. It watches five request lines: a non-maskable trap, three restart requests (named 7.5, 6.5 and 5.5 after their rank), and one general request. For the general request the core takes the next instruction from the external bus instead of using a vector.

The core reports each instruction boundary with a strobe. At a boundary the controller picks the highest-ranked request that is both pending and allowed. One cycle later it raises a take strobe, together with a fixed 16-bit restart address or, for the general request, an acknowledge pulse. The core pushes the program counter and branches to the address, or fetches the externally supplied instruction.

The controller also holds the state that allows requests: a single global enable flag and a three-bit mask register. The core's enable, disable and set-mask instructions change this state. Each one is reported as a qualifier on the boundary strobe of the instruction that retires.

Top module: `irq_arbiter`

## Requirements
- R1: After synchronous reset, take_o and gen_ack_o are low, vector_o is zero, ien_o is low and mask_o is 3'b111 (all restart sources masked).
- R2: Arbitration happens only on a cycle with boundary_i high, and the result appears on take_o in the following cycle. The ranking from highest to lowest is trap, restart 7.5, restart 6.5, restart 5.5, general request. When take_o is low, vector_o is zero and gen_ack_o is low.
- R3: A taken trap gives vector 0x0024, restart 7.5 gives 0x003C, restart 6.5 gives 0x0034 and restart 5.5 gives 0x002C. A taken general request gives gen_ack_o high with vector_o zero.
- R4: The trap is captured on a rising edge of trap_i, held until it is taken, and taken regardless of the enable flag and the masks.
- R5: Restart and general requests are taken only while the global enable is set. A boundary that retires a disable instruction (di_i high) does not take them.
- R6: A boundary that retires an enable instruction (ei_i high) sets the global enable but takes no maskable request. The next boundary may take one.
- R7: Taking any request, the trap included, clears the global enable. When a take and an enable instruction fall on the same boundary, the take wins and ien_o ends low.
- R8: A boundary with mask_ld_i high loads mask_o from mask_val_i. Bit 2 masks restart 7.5, bit 1 masks 6.5, bit 0 masks 5.5, and 1 means masked. The new mask applies from the next boundary. The masks never block the general request.
- R9: A rising edge on req75_i is latched even while 7.5 is masked or the enable is low. The latch is held until 7.5 is taken or a set-mask boundary with clr75_i high clears it. A rising edge in the same cycle as such a clear leaves the latch set.
- R10: Restarts 6.5 and 5.5 are level requests: they are taken only if high in the boundary cycle.
- R11: ei_i, di_i and mask_ld_i have no effect in a cycle without boundary_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| ei_i | input | 1 | Retiring instruction is the enable instruction |
| di_i | input | 1 | Retiring instruction is the disable instruction |
| mask_ld_i | input | 1 | Retiring instruction is the set-mask operation |
| mask_val_i | input | 3 | New mask bits {7.5, 6.5, 5.5}, 1 = masked |
| clr75_i | input | 1 | Set-mask operation also clears the 7.5 latch |
| trap_i | input | 1 | Non-maskable trap request (edge captured) |
| req75_i | input | 1 | Restart 7.5 request (edge captured) |
| req65_i | input | 1 | Restart 6.5 request (level) |
| req55_i | input | 1 | Restart 5.5 request (level) |
| gen_req_i | input | 1 | General request serviced by an external instruction |
| take_o | output | 1 | An interrupt is being taken |
| vector_o | output | 16 | Restart address of the taken source |
| gen_ack_o | output | 1 | Acknowledge for the general request |
| ien_o | output | 1 | Global enable flag |
| mask_o | output | 3 | Current mask register |

## Verification
Two pairs of functions can fall on the same cycle, and the bench provokes each directly. In the first, a latched trap is taken on the very boundary that retires an enable instruction. The take must win, so ien_o reads low. In the second, a new rising edge on req75_i arrives in the same cycle as a set-mask operation that clears the 7.5 latch. The edge must survive, so the following boundary must yield vector 0x003C. A behavioural reference model is compared with every output on every clock, and it judges both outcomes.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int VEC_W  = 16;
    localparam int NSRC   = 5;
    localparam int NMASK  = 3;
    localparam int NEDGE  = 2;

    // Bit positions in the request vector; a higher index means higher rank.
    localparam int IDX_GEN  = 0;
    localparam int IDX_R55  = 1;
    localparam int IDX_R65  = 2;
    localparam int IDX_R75  = 3;
    localparam int IDX_TRAP = 4;

    // Mask bit positions inside the mask register.
    localparam int MB_R55 = 0;
    localparam int MB_R65 = 1;
    localparam int MB_R75 = 2;

    // Edge-latch slots.
    localparam int E_TRAP = 0;
    localparam int E_R75  = 1;

    localparam logic [VEC_W-1:0] VEC_TRAP = VEC_W'('h0024);
    localparam logic [VEC_W-1:0] VEC_R75  = VEC_W'('h003C);
    localparam logic [VEC_W-1:0] VEC_R65  = VEC_W'('h0034);
    localparam logic [VEC_W-1:0] VEC_R55  = VEC_W'('h002C);

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_GEN  = 3'd1,
        SRC_R55  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R75  = 3'd4,
        SRC_TRAP = 3'd5
    } irq_src_e;

    typedef struct packed {
        logic             take;
        logic             ack;
        logic [VEC_W-1:0] vec;
    } irq_grant_t;

    function automatic irq_src_e idx_to_src(input int idx);
        case (idx)
            IDX_GEN:  return SRC_GEN;
            IDX_R55:  return SRC_R55;
            IDX_R65:  return SRC_R65;
            IDX_R75:  return SRC_R75;
            IDX_TRAP: return SRC_TRAP;
            default:  return SRC_NONE;
        endcase
    endfunction

    function automatic logic [VEC_W-1:0] vector_of(input irq_src_e s);
        case (s)
            SRC_TRAP: return VEC_TRAP;
            SRC_R75:  return VEC_R75;
            SRC_R65:  return VEC_R65;
            SRC_R55:  return VEC_R55;
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic din_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise   = din_i & ~prev_q;
    assign pend_o = pend_q;

    // A fresh edge outranks a clear arriving in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= din_i;
            pend_q <= rise | (pend_q & ~clr_i);
        end
    end

    // R9
    edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (din_i && !prev_q) |=> pend_o);

    // R4
    pend_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !clr_i) |=> pend_o);

endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_oh_o,
    output irq_src_e     src_o
);
    // Walk upward so the highest-indexed request overrides lower ones.
    always_comb begin
        grant_oh_o = '0;
        src_o      = SRC_NONE;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) begin
                grant_oh_o    = '0;
                grant_oh_o[i] = 1'b1;
                src_o         = idx_to_src(i);
            end
        end
    end

    // R2
    always_comb begin
        grant_onehot_chk: assert ($onehot0(grant_oh_o));
    end

    // R2
    always_comb begin
        grant_has_req_chk: assert ((grant_oh_o & ~req_i) == '0);
    end

endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl
    import irq_pkg::*;
#(
    parameter int NM = NMASK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boundary_i,
    input  logic          ei_i,
    input  logic          di_i,
    input  logic          accept_i,
    input  logic          mask_ld_i,
    input  logic [NM-1:0] mask_val_i,
    output logic          ien_o,
    output logic [NM-1:0] mask_o,
    output logic          gate_o
);
    logic          ien_q;
    logic [NM-1:0] mask_q;
    logic          ei_ret;
    logic          di_ret;

    assign ei_ret = boundary_i & ei_i;
    assign di_ret = boundary_i & di_i;

    // Maskable sources are allowed only when the flag was already set and
    // the retiring instruction is neither an enable nor a disable.
    assign gate_o = ien_q & ~ei_ret & ~di_ret;
    assign ien_o  = ien_q;
    assign mask_o = mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= 1'b0;
            mask_q <= '1;
        end else begin
            if (boundary_i) begin
                if (accept_i)    ien_q <= 1'b0;
                else if (di_i)   ien_q <= 1'b0;
                else if (ei_i)   ien_q <= 1'b1;
            end
            if (boundary_i && mask_ld_i) begin
                mask_q <= mask_val_i;
            end
        end
    end

    // R7
    accept_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && accept_i) |=> !ien_o);

    // R6
    ei_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && ei_i && !di_i && !accept_i) |=> ien_o);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !boundary_i |=> ($stable(ien_o) && $stable(mask_o)));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary_i,
    input  logic             ei_i,
    input  logic             di_i,
    input  logic             mask_ld_i,
    input  logic [NMASK-1:0] mask_val_i,
    input  logic             clr75_i,
    input  logic             trap_i,
    input  logic             req75_i,
    input  logic             req65_i,
    input  logic             req55_i,
    input  logic             gen_req_i,
    output logic             take_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             gen_ack_o,
    output logic             ien_o,
    output logic [NMASK-1:0] mask_o
);
    logic [NEDGE-1:0] edge_din;
    logic [NEDGE-1:0] edge_clr;
    logic [NEDGE-1:0] edge_pend;
    logic [NSRC-1:0]  req;
    logic [NSRC-1:0]  grant_oh;
    irq_src_e         src;
    logic             accept;
    logic             gate;
    irq_grant_t       grant_q;

    assign edge_din[E_TRAP] = trap_i;
    assign edge_din[E_R75]  = req75_i;

    assign edge_clr[E_TRAP] = grant_oh[IDX_TRAP];
    assign edge_clr[E_R75]  = grant_oh[IDX_R75] | (boundary_i & mask_ld_i & clr75_i);

    for (genvar g = 0; g < NEDGE; g++) begin : g_edge
        irq_edge_latch u_latch (
            .clk    (clk),
            .rst    (rst),
            .din_i  (edge_din[g]),
            .clr_i  (edge_clr[g]),
            .pend_o (edge_pend[g])
        );
    end

    irq_enable_ctl #(.NM(NMASK)) u_en (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (boundary_i),
        .ei_i       (ei_i),
        .di_i       (di_i),
        .accept_i   (accept),
        .mask_ld_i  (mask_ld_i),
        .mask_val_i (mask_val_i),
        .ien_o      (ien_o),
        .mask_o     (mask_o),
        .gate_o     (gate)
    );

    always_comb begin
        req           = '0;
        req[IDX_TRAP] = boundary_i & edge_pend[E_TRAP];
        req[IDX_R75]  = boundary_i & gate & edge_pend[E_R75] & ~mask_o[MB_R75];
        req[IDX_R65]  = boundary_i & gate & req65_i & ~mask_o[MB_R65];
        req[IDX_R55]  = boundary_i & gate & req55_i & ~mask_o[MB_R55];
        req[IDX_GEN]  = boundary_i & gate & gen_req_i;
    end

    irq_prio #(.N(NSRC)) u_prio (
        .req_i      (req),
        .grant_oh_o (grant_oh),
        .src_o      (src)
    );

    assign accept = |grant_oh;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else begin
            grant_q.take <= accept;
            grant_q.ack  <= grant_oh[IDX_GEN];
            grant_q.vec  <= vector_of(src);
        end
    end

    assign take_o    = grant_q.take;
    assign gen_ack_o = grant_q.ack;
    assign vector_o  = grant_q.vec;

    // R2
    take_after_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(boundary_i));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (vector_o == '0 && !gen_ack_o));

    // R3
    gen_ack_chk: assert property (@(posedge clk) disable iff (rst)
        gen_ack_o |-> (take_o && vector_o == '0));

    // R4
    trap_first_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && edge_pend[E_TRAP]) |=> (take_o && vector_o == VEC_TRAP));

    // R7
    take_clears_ien_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !ien_o);

endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary_i = 1'b0;
    logic        ei_i = 1'b0;
    logic        di_i = 1'b0;
    logic        mask_ld_i = 1'b0;
    logic [2:0]  mask_val_i = 3'b000;
    logic        clr75_i = 1'b0;
    logic        trap_i = 1'b0;
    logic        req75_i = 1'b0;
    logic        req65_i = 1'b0;
    logic        req55_i = 1'b0;
    logic        gen_req_i = 1'b0;
    logic        take_o;
    logic [15:0] vector_o;
    logic        gen_ack_o;
    logic        ien_o;
    logic [2:0]  mask_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state
    int m_ien, m_mask, m_p75, m_ptrap, m_prev75, m_prevtrap;
    int m_take, m_vec, m_ack;

    irq_arbiter u_dut (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (boundary_i),
        .ei_i       (ei_i),
        .di_i       (di_i),
        .mask_ld_i  (mask_ld_i),
        .mask_val_i (mask_val_i),
        .clr75_i    (clr75_i),
        .trap_i     (trap_i),
        .req75_i    (req75_i),
        .req65_i    (req65_i),
        .req55_i    (req55_i),
        .gen_req_i  (gen_req_i),
        .take_o     (take_o),
        .vector_o   (vector_o),
        .gen_ack_o  (gen_ack_o),
        .ien_o      (ien_o),
        .mask_o     (mask_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model of the requirements, updated on every rising edge.
    always @(posedge clk) begin
        int  ok, rise75, risetrap, took;
        if (rst) begin
            m_ien = 0; m_mask = 7; m_p75 = 0; m_ptrap = 0;
            m_prev75 = 0; m_prevtrap = 0;
            m_take = 0; m_vec = 0; m_ack = 0;
        end else begin
            rise75   = (req75_i && !m_prev75) ? 1 : 0;
            risetrap = (trap_i && !m_prevtrap) ? 1 : 0;
            m_take = 0; m_vec = 0; m_ack = 0; took = 0;
            if (boundary_i) begin
                ok = (m_ien != 0 && !ei_i && !di_i) ? 1 : 0;
                if (m_ptrap != 0) begin
                    m_take = 1; m_vec = 'h24; took = 5;
                end else if (ok != 0 && m_p75 != 0 && m_mask[2] == 0) begin
                    m_take = 1; m_vec = 'h3C; took = 4;
                end else if (ok != 0 && req65_i && m_mask[1] == 0) begin
                    m_take = 1; m_vec = 'h34; took = 3;
                end else if (ok != 0 && req55_i && m_mask[0] == 0) begin
                    m_take = 1; m_vec = 'h2C; took = 2;
                end else if (ok != 0 && gen_req_i) begin
                    m_take = 1; m_ack = 1; took = 1;
                end
            end
            if (took == 4 || (boundary_i && mask_ld_i && clr75_i)) m_p75 = 0;
            if (rise75 != 0) m_p75 = 1;
            if (took == 5) m_ptrap = 0;
            if (risetrap != 0) m_ptrap = 1;
            if (boundary_i) begin
                if (took != 0)   m_ien = 0;
                else if (di_i)   m_ien = 0;
                else if (ei_i)   m_ien = 1;
                if (mask_ld_i)   m_mask = mask_val_i;
            end
            m_prev75   = req75_i;
            m_prevtrap = trap_i;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 take", take_o, m_take);
            check("R3 vector", vector_o, m_vec);
            check("R3 gen_ack", gen_ack_o, m_ack);
            check("R7 ien", ien_o, m_ien);
            check("R8 mask", mask_o, m_mask);
        end
    end

    // Called at a falling edge; drives one boundary cycle and returns at the
    // next falling edge, when the registered result is visible.
    task automatic bnd(input bit ei, input bit di, input bit ml,
                       input logic [2:0] mv, input bit clr);
        boundary_i = 1'b1; ei_i = ei; di_i = di;
        mask_ld_i = ml; mask_val_i = mv; clr75_i = clr;
        @(negedge clk);
        boundary_i = 1'b0; ei_i = 1'b0; di_i = 1'b0;
        mask_ld_i = 1'b0; mask_val_i = 3'b000; clr75_i = 1'b0;
    endtask

    task automatic plain();
        bnd(1'b0, 1'b0, 1'b0, 3'b000, 1'b0);
    endtask

    task automatic enable();
        bnd(1'b1, 1'b0, 1'b0, 3'b000, 1'b0);
    endtask

    task automatic setmask(input logic [2:0] mv, input bit clr);
        bnd(1'b0, 1'b0, 1'b1, mv, clr);
    endtask

    task automatic pulse75();
        req75_i = 1'b1; @(negedge clk); req75_i = 1'b0;
    endtask

    task automatic pulse_trap();
        trap_i = 1'b1; @(negedge clk); trap_i = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 take", take_o, 0);
        check("R1 vector", vector_o, 0);
        check("R1 ien", ien_o, 0);
        check("R1 mask", mask_o, 3'b111);

        // R11: qualifiers without a boundary do nothing
        ei_i = 1'b1; mask_ld_i = 1'b1; mask_val_i = 3'b000; di_i = 1'b0;
        @(negedge clk);
        ei_i = 1'b0; mask_ld_i = 1'b0;
        @(negedge clk);
        check("R11 ien", ien_o, 0);
        check("R11 mask", mask_o, 3'b111);

        // R6 enable, R8 mask load applies from the next boundary
        req55_i = 1'b1;
        enable();
        check("R6 ien set", ien_o, 1);
        check("R6 no take", take_o, 0);
        setmask(3'b000, 1'b0);
        check("R8 old mask blocks", take_o, 0);
        check("R8 mask loaded", mask_o, 3'b000);
        repeat (3) @(negedge clk);
        check("R2 no boundary no take", take_o, 0);
        plain();
        check("R10 take 5.5", take_o, 1);
        check("R3 vector 5.5", vector_o, 'h2C);
        check("R7 ien cleared", ien_o, 0);
        plain();
        check("R5 ien low blocks", take_o, 0);
        req55_i = 1'b0;

        // R4 trap regardless of enable
        pulse_trap();
        repeat (2) @(negedge clk);
        plain();
        check("R4 trap take", take_o, 1);
        check("R3 trap vector", vector_o, 'h24);
        plain();
        check("R4 trap cleared", take_o, 0);

        // R6 delay after enable
        req65_i = 1'b1;
        enable();
        check("R6 ei boundary blocks", take_o, 0);
        plain();
        check("R6 next boundary takes", vector_o, 'h34);
        req65_i = 1'b0;

        // R2 ranking
        req55_i = 1'b1; req65_i = 1'b1; gen_req_i = 1'b1;
        pulse75();
        enable();
        check("R6 blocked with all pending", take_o, 0);
        plain();
        check("R2 7.5 first", vector_o, 'h3C);
        enable(); plain();
        check("R2 6.5 next", vector_o, 'h34);
        req65_i = 1'b0;
        enable(); plain();
        check("R2 5.5 next", vector_o, 'h2C);
        req55_i = 1'b0;
        enable(); plain();
        check("R3 general take", take_o, 1);
        check("R3 general ack", gen_ack_o, 1);
        check("R3 general vector", vector_o, 0);
        gen_req_i = 1'b0;

        // R9 masked 7.5 edge is held
        enable();
        setmask(3'b100, 1'b0);
        pulse75();
        plain();
        check("R9 masked no take", take_o, 0);
        check("R9 ien kept", ien_o, 1);
        setmask(3'b000, 1'b0);
        check("R8 unmask applies later", take_o, 0);
        plain();
        check("R9 held edge taken", vector_o, 'h3C);

        // R9 clear by set-mask
        enable();
        setmask(3'b100, 1'b0);
        pulse75();
        setmask(3'b000, 1'b1);
        check("R9 clear boundary", take_o, 0);
        plain();
        check("R9 cleared latch", take_o, 0);

        // R9 new edge in the clearing cycle survives
        req75_i = 1'b1;
        setmask(3'b000, 1'b1);
        req75_i = 1'b0;
        check("R9 coincident no take yet", take_o, 0);
        plain();
        check("R9 coincident edge kept", vector_o, 'h3C);

        // R7 take beats enable on the same boundary
        pulse_trap();
        enable();
        check("R7 trap on ei boundary", vector_o, 'h24);
        check("R7 ien low after", ien_o, 0);

        // R5 disable boundary blocks
        enable();
        req55_i = 1'b1;
        bnd(1'b0, 1'b1, 1'b0, 3'b000, 1'b0);
        check("R5 di boundary no take", take_o, 0);
        check("R5 ien cleared", ien_o, 0);
        req55_i = 1'b0;

        // R8 masks do not block the general request
        setmask(3'b111, 1'b0);
        gen_req_i = 1'b1;
        enable();
        plain();
        check("R8 general with masks", gen_ack_o, 1);
        check("R8 mask still set", mask_o, 3'b111);
        gen_req_i = 1'b0;

        // R10 level request dropped before boundary
        setmask(3'b000, 1'b0);
        enable();
        req65_i = 1'b1; @(negedge clk); req65_i = 1'b0;
        plain();
        check("R10 dropped level", take_o, 0);
        check("R10 ien still set", ien_o, 1);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule